// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Sequencer

This block owns the two chip-enable levels of a pseudo-static RAM whenever the bus controller is not in the middle of an access. Out of reset it holds both enables high for a fixed settling time. Only then does it tell the bus controller, through a ready flag, that accesses may run. While idle it keeps the memory in standby, where contents are retained. An access-pending input moves it to the active level (primary enable low). When no access is pending, a power-down request drives the secondary enable low. This enters a deep power-down in which the memory loses its contents.

Releasing the request raises the secondary enable again. That sends the sequencer back to its initial state, and the full settling wait runs again before the ready flag returns. A data-valid flag tells software whether the memory still holds what it wrote. Entering power-down clears the flag. It is set again only when software acknowledges that contents have been reloaded.

Top module: `psram_power_seq`

## Requirements
- R1: While reset is asserted and in the cycle after release, ce1_n = 1, ce2 = 1, ready = 0 and data_valid = 0.
- R2: The settling wait lasts WAIT_CYCLES = WAIT_US * 1,000,000 / CLK_PERIOD_PS clock cycles. ready rises at exactly the WAIT_CYCLES-th rising edge after reset release, and both enables stay high throughout the wait.
- R3: In standby (ready = 1, ce1_n = 1, ce2 = 1), acc_pend = 1 at an edge drives ce1_n low from that edge. ce1_n returns high at the first edge with acc_pend = 0. ready stays 1 throughout.
- R4: In standby, pd_req = 1 with acc_pend = 0 at an edge drives ce2 low and ready low from that edge. When both are high, acc_pend takes priority and the block enters active instead.
- R5: pd_req while active (ce1_n = 0) has no effect. When the access ends, the block first returns to standby for at least one cycle, and only the next edge can take it to power-down.
- R6: A valid_ack pulse sampled while ready = 1 sets data_valid at that edge. A valid_ack sampled while ready = 0 is ignored.
- R7: data_valid clears at the same edge that drives ce2 low. A valid_ack sampled at that same edge does not set it.
- R8: In power-down, the first edge with pd_req = 0 raises ce2 with ready = 0. The wait then restarts from zero, and ready rises WAIT_CYCLES edges later.
- R9: During the settling wait, acc_pend and pd_req have no effect. ce1_n is never low while ce2 is low or ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_pend | input | 1 | Bus controller has an access to run |
| pd_req | input | 1 | Request for deep power-down (level) |
| valid_ack | input | 1 | Software acknowledges that memory contents were reloaded |
| ce1_n | output | 1 | Primary chip enable, active low |
| ce2 | output | 1 | Secondary chip enable; low selects deep power-down |
| ready | output | 1 | Accesses may be run |
| data_valid | output | 1 | Memory contents are intact |

## Verification
Suppose the wait counter fails to restart on re-entry to the initial state. ready would then rise too early after leaving power-down, and the very first edge it should hold off would expose the fault. A wrong state encoding or transition shows on the enable pins one cycle after the offending input, because the enables are registered straight from the next state. A stale data-valid flag stays visible on data_valid from the power-down entry onward, until the next acknowledge taken while ready is high.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [1:0] {
        PS_INIT    = 2'd0,
        PS_STANDBY = 2'd1,
        PS_ACTIVE  = 2'd2,
        PS_PWRDN   = 2'd3
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       ce1_n;
        logic       ce2;
        logic       ready;
    } fsm_regs_t;

endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
    parameter int WAIT_CYCLES = 35000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Counts only while running; any cycle outside the wait clears it,
    // so every entry to the initial state starts from zero.
    always_comb begin
        cnt_d = '0;
        if (run && (cnt_q != LAST)) cnt_d = cnt_q + 1'b1;
        done = run && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_done,
    input  logic       acc_pend,
    input  logic       pd_req,
    output pwr_state_e state,
    output logic       ce1_n,
    output logic       ce2,
    output logic       ready,
    output logic       pd_entry
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        pd_entry = 1'b0;
        unique case (r_q.st)
            PS_INIT:    if (wait_done) r_d.st = PS_STANDBY;
            PS_STANDBY: begin
                if (acc_pend) begin
                    r_d.st = PS_ACTIVE;
                end else if (pd_req) begin
                    r_d.st   = PS_PWRDN;
                    pd_entry = 1'b1;
                end
            end
            PS_ACTIVE:  if (!acc_pend) r_d.st = PS_STANDBY;
            PS_PWRDN:   if (!pd_req) r_d.st = PS_INIT;
            default:    r_d.st = PS_INIT;
        endcase
        // Pin levels registered from the next state: glitch-free outputs.
        r_d.ce1_n = (r_d.st != PS_ACTIVE);
        r_d.ce2   = (r_d.st != PS_PWRDN);
        r_d.ready = (r_d.st == PS_STANDBY) || (r_d.st == PS_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PS_INIT, ce1_n: 1'b1, ce2: 1'b1, ready: 1'b0};
        else        r_q <= r_d;
    end

    assign state = r_q.st;
    assign ce1_n = r_q.ce1_n;
    assign ce2   = r_q.ce2;
    assign ready = r_q.ready;
endmodule

// File: rtl/psram_valid_flag.sv
module psram_valid_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic pd_entry,
    input  logic ack,
    output logic valid
);
    logic valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (pd_entry)         valid_d = 1'b0;  // loss of contents wins
        else if (ack && ready) valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign valid = valid_q;
endmodule

// File: rtl/psram_power_seq.sv
module psram_power_seq
    import psram_pwr_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int WAIT_US       = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_pend,
    input  logic pd_req,
    input  logic valid_ack,
    output logic ce1_n,
    output logic ce2,
    output logic ready,
    output logic data_valid
);
    localparam longint WAIT_PS     = longint'(WAIT_US) * 64'd1000000;
    localparam int     WAIT_CYCLES = int'((WAIT_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS);

    pwr_state_e state;
    logic       wait_done;
    logic       pd_entry;

    psram_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == PS_INIT),
        .done  (wait_done)
    );

    psram_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_done (wait_done),
        .acc_pend  (acc_pend),
        .pd_req    (pd_req),
        .state     (state),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ready     (ready),
        .pd_entry  (pd_entry)
    );

    psram_valid_flag u_valid (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .pd_entry (pd_entry),
        .ack      (valid_ack),
        .valid    (data_valid)
    );
endmodule

// File: rtl/psram_power_seq_chk.sv
module psram_power_seq_chk #(
    parameter int WAIT_CYCLES = 35000
) (
    input logic clk,
    input logic rst_n,
    input logic acc_pend,
    input logic pd_req,
    input logic ce1_n,
    input logic ce2,
    input logic ready,
    input logic data_valid
);
    // Cycles spent in the settling wait, counted independently of the design.
    logic [31:0] wait_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               wait_seen <= '0;
        else if (ce2 && !ready)   wait_seen <= wait_seen + 1'b1;
        else                      wait_seen <= '0;
    end

    assert_wait_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (wait_seen == WAIT_CYCLES));

    assert_active_on_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce1_n) |-> $past(acc_pend));

    assert_pd_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce2) |-> ($past(pd_req) && !$past(acc_pend) && $past(ready) && $past(ce1_n)));

    assert_pd_clears_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2 |-> !data_valid);

    assert_pd_exit_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2 |=> !ready);

    assert_ce1_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce1_n |-> (ce2 && ready));
endmodule

bind psram_power_seq psram_power_seq_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_pend   (acc_pend),
    .pd_req     (pd_req),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ready      (ready),
    .data_valid (data_valid)
);

// File: tb/psram_power_seq_bench.sv
module psram_power_seq_bench;
    localparam int CLK_PS = 10000;
    localparam int W_US   = 1;
    localparam int W      = W_US * 1000000 / CLK_PS;  // 100 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_pend = 1'b0, pd_req = 1'b0, valid_ack = 1'b0;
    logic ce1_n, ce2, ready, data_valid;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // model: 0 init, 1 standby, 2 active, 3 power-down
    int m_st = 0;
    int m_cnt = 0;
    bit m_valid = 1'b0;

    always #5ns clk = ~clk;

    psram_power_seq #(.CLK_PERIOD_PS(CLK_PS), .WAIT_US(W_US)) u_psram_power_seq (
        .clk(clk), .rst_n(rst_n), .acc_pend(acc_pend), .pd_req(pd_req),
        .valid_ack(valid_ack), .ce1_n(ce1_n), .ce2(ce2), .ready(ready),
        .data_valid(data_valid)
    );

    function automatic bit exp_ce1_n(int s); return s != 2; endfunction
    function automatic bit exp_ce2(int s);   return s != 3; endfunction
    function automatic bit exp_ready(int s); return (s == 1) || (s == 2); endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(bit a, bit p, bit k);
        bit rdy = exp_ready(m_st);
        bit pde = (m_st == 1) && !a && p;
        if (pde) m_valid = 1'b0;
        else if (k && rdy) m_valid = 1'b1;
        case (m_st)
            0: if (m_cnt == W - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
            1: if (a) m_st = 2; else if (p) m_st = 3;
            2: if (!a) m_st = 1;
            default: if (!p) begin m_st = 0; m_cnt = 0; end
        endcase
    endtask

    task automatic compare_all();
        chk("R2 ready", ready, exp_ready(m_st));
        chk("R3 ce1_n", ce1_n, exp_ce1_n(m_st));
        chk("R4 ce2", ce2, exp_ce2(m_st));
        chk("R6 data_valid", data_valid, m_valid);
    endtask

    // Called at a falling edge: drive, take one rising edge, compare at next falling edge.
    task automatic step(bit a, bit p, bit k);
        acc_pend = a; pd_req = p; valid_ack = k;
        @(posedge clk);
        model_edge(a, p, k);
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        bit ha, hp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ce1_n", ce1_n, 1'b1);
        chk("R1 ce2", ce2, 1'b1);
        chk("R1 ready", ready, 1'b0);
        chk("R1 data_valid", data_valid, 1'b0);
        rst_n = 1'b1;
        compare_all();

        // R9 / R2: inputs ignored during wait; ready at edge W exactly
        for (int i = 0; i < W - 1; i++) step(1'b1, 1'b1, 1'b1);
        chk("R9 ce1_n during wait", ce1_n, 1'b1);
        chk("R9 ce2 during wait", ce2, 1'b1);
        chk("R2 ready before end", ready, 1'b0);
        chk("R6 ack ignored while not ready", data_valid, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R2 ready at end of wait", ready, 1'b1);

        // R6: ack while ready sets data_valid
        step(1'b0, 1'b0, 1'b1);
        chk("R6 valid set", data_valid, 1'b1);
        // R4: access wins over power-down
        step(1'b1, 1'b1, 1'b0);
        chk("R4 access priority ce1_n", ce1_n, 1'b0);
        chk("R4 access priority ce2", ce2, 1'b1);
        // R5: pd ignored while active
        step(1'b1, 1'b1, 1'b0);
        chk("R5 still active", ce1_n, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R5 standby first ce1_n", ce1_n, 1'b1);
        chk("R5 standby first ce2", ce2, 1'b1);
        chk("R3 ready kept", ready, 1'b1);
        // R7: pd entry clears valid even with ack at same edge
        step(1'b0, 1'b1, 1'b1);
        chk("R4 ce2 low", ce2, 1'b0);
        chk("R4 ready low", ready, 1'b0);
        chk("R7 valid cleared", data_valid, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk("R6 ack ignored in power-down", data_valid, 1'b0);
        chk("R9 no access in power-down", ce1_n, 1'b1);
        // R8: exit re-runs the full wait
        step(1'b0, 1'b0, 1'b0);
        chk("R8 ce2 high", ce2, 1'b1);
        chk("R8 ready low", ready, 1'b0);
        for (int i = 0; i < W - 1; i++) step(1'b0, 1'b0, 1'b0);
        chk("R8 ready still low", ready, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R8 ready after rewait", ready, 1'b1);

        // Random phase with slowly changing levels
        ha = 1'b0; hp = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 7) == 0) ha = ~ha;
            if ($urandom_range(0, 39) == 0) hp = ~hp;
            step(ha, hp, $urandom_range(0, 9) == 0);
        end
        finish_run();
    end
endmodule